// File: doc/BRIEF.md
# Early-Terminating Radix-4 Booth Multiplier

This block multiplies two signed integers over several clock cycles and returns the low half of the two's-complement product. It recodes the multiplier operand two bits at a time into the signed digits {-2, -1, 0, +1, +2}. Each digit adds a selected multiple of the multiplicand into an accumulator, and the multiplicand is then shifted left by two places. The loop stops as soon as every multiplier digit still to come is zero. This happens when the unconsumed multiplier bits, together with the last bit consumed, are all zeros or all ones. Because of this early exit, latency follows the number of significant bits in the multiplier operand rather than the word width.

A host raises `start_i` for one cycle with both operands. The block raises `busy_o` from the next cycle until its single-cycle `done_o`, and the product appears on `product_o` in the done cycle. Only one multiply runs at a time. A start seen while busy is dropped. The product register holds its value until the done cycle of the next multiply.

The controller has seven states:

- IDLE: waits for a start and captures the operands.
- LOAD: clears the accumulator and the Booth history bit.
- PREP: clears the digit counter.
- ITER: one Booth digit per cycle.
- DRAIN: moves the accumulator into a result stage.
- STORE: writes the product register.
- DONE: pulses done.

The transitions are:

- IDLE to LOAD on start.
- LOAD to PREP.
- PREP to ITER.
- ITER to ITER while more digits remain.
- ITER to DRAIN on the stop condition.
- DRAIN to STORE.
- STORE to DONE.
- DONE to IDLE.

The minimum-iteration floor `MIN_ITER` and the five fixed control steps set the shortest latency.

Top module: `eo_booth_mul`

## Requirements
- R1: `product_o` in the done cycle equals bits [WIDTH-1:0] of the signed product of `mcand_i` and `mplier_i` as captured with the accepted start.
- R2: Let s be the smallest width in which `mplier_i` fits as a signed number (from 1 to WIDTH). Let n be the larger of MIN_ITER and ceil(s/2). Latency L = n + 5, where L counts rising edges, with the edge that samples start as edge 1 and `done_o` high right after edge L.
- R3: With the default parameters, any multiplier operand of 8 or fewer significant bits (for example 0, -1, 1, 127, -128) gives the minimum latency of 9.
- R4: With the default parameters, a full-width multiplier operand gives the maximum latency of 21, and an operand of 26 significant bits gives 18.
- R5: `busy_o` is 1 in every cycle from the one after the accepted start through the done cycle, and 0 in the cycle after done.
- R6: A start raised while `busy_o` is 1 is ignored: the running product and its latency are unchanged, and no further operation begins after done.
- R7: `done_o` is high for exactly one cycle per accepted start.
- R8: `product_o` changes only in a cycle where `done_o` is 1; it holds while idle and while a following operation is running.
- R9: After reset, `busy_o`, `done_o` and `product_o` are all 0.
- R10: The multiplicand value has no effect on latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mcand_i | input | WIDTH | Signed multiplicand, sampled with start |
| mplier_i | input | WIDTH | Signed multiplier, sampled with start; sets latency |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | WIDTH | Low WIDTH bits of the signed product |

## Verification
The bench builds the block with WIDTH = 32 and MIN_ITER = 4, the values that give the 9-to-21-cycle latency window. This brings the minimum floor, the 18-cycle point at 26 significant bits and the full 16-digit path within reach. Random multiplier operands are arithmetically shifted by a random amount, so every significant-bit count from 1 to 32 occurs. Each operation is checked against a bench-computed product and latency. Directed cases cover the latency boundaries, a start injected mid-operation, and product hold while idle.

// File: rtl/eo_mul_pkg.sv
package eo_mul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_PREP  = 3'd2,
        ST_ITER  = 3'd3,
        ST_DRAIN = 3'd4,
        ST_STORE = 3'd5,
        ST_DONE  = 3'd6
    } mul_state_e;

    typedef struct packed {
        logic zero;
        logic dbl;
        logic neg;
    } booth_sel_t;

endpackage

// File: rtl/eo_booth_recode.sv
module eo_booth_recode
    import eo_mul_pkg::*;
(
    input  logic [2:0] triple_i,
    output booth_sel_t sel_o
);
    always_comb begin
        sel_o = '{zero: 1'b1, dbl: 1'b0, neg: 1'b0};
        unique case (triple_i)
            3'b000, 3'b111: sel_o = '{zero: 1'b1, dbl: 1'b0, neg: 1'b0};
            3'b001, 3'b010: sel_o = '{zero: 1'b0, dbl: 1'b0, neg: 1'b0};
            3'b011:         sel_o = '{zero: 1'b0, dbl: 1'b1, neg: 1'b0};
            3'b100:         sel_o = '{zero: 1'b0, dbl: 1'b1, neg: 1'b1};
            3'b101, 3'b110: sel_o = '{zero: 1'b0, dbl: 1'b0, neg: 1'b1};
            default:        sel_o = '{zero: 1'b1, dbl: 1'b0, neg: 1'b0};
        endcase
    end
endmodule

// File: rtl/eo_booth_pp.sv
module eo_booth_pp
    import eo_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] mcand_i,
    input  booth_sel_t       sel_i,
    output logic [WIDTH-1:0] pp_o
);
    logic [WIDTH-1:0] mag;

    always_comb begin
        if (sel_i.zero) begin
            mag = '0;
        end else if (sel_i.dbl) begin
            mag = {mcand_i[WIDTH-2:0], 1'b0};
        end else begin
            mag = mcand_i;
        end
        pp_o = sel_i.neg ? (~mag + {{(WIDTH-1){1'b0}}, 1'b1}) : mag;
    end
endmodule

// File: rtl/eo_early_out.sv
module eo_early_out #(
    parameter int WIDTH    = 32,
    parameter int MIN_ITER = 4
) (
    input  logic [WIDTH:0]                      rest_i,
    input  logic [$clog2(WIDTH/2 + 1)-1:0]      next_cnt_i,
    output logic                                stop_o
);
    localparam int ITERS = WIDTH / 2;
    localparam int CW    = $clog2(ITERS + 1);

    logic uniform;
    logic floor_met;
    logic at_last;

    always_comb begin
        uniform   = (&rest_i) | (~|rest_i);
        floor_met = (next_cnt_i >= CW'(MIN_ITER));
        at_last   = (next_cnt_i == CW'(ITERS));
        stop_o    = floor_met & (uniform | at_last);
    end
endmodule

// File: rtl/eo_mul_fsm.sv
module eo_mul_fsm
    import eo_mul_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    output mul_state_e state_o,
    output logic       busy_o,
    output logic       done_o
);
    mul_state_e state_q;
    mul_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = start_i ? ST_LOAD : ST_IDLE;
            ST_LOAD:  state_d = ST_PREP;
            ST_PREP:  state_d = ST_ITER;
            ST_ITER:  state_d = stop_i ? ST_DRAIN : ST_ITER;
            ST_DRAIN: state_d = ST_STORE;
            ST_STORE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state_o = state_q;
        busy_o  = (state_q != ST_IDLE);
        done_o  = (state_q == ST_DONE);
    end

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> (state_q != ST_LOAD)); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R5
endmodule

// File: rtl/eo_booth_mul.sv
module eo_booth_mul
    import eo_mul_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int MIN_ITER = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] product_o
);
    localparam int ITERS = WIDTH / 2;
    localparam int CW    = $clog2(ITERS + 1);

    mul_state_e        state;
    logic [WIDTH-1:0]  mcand_q;
    logic [WIDTH-1:0]  mplr_q;
    logic              hist_q;
    logic [WIDTH-1:0]  acc_q;
    logic [WIDTH-1:0]  sum_q;
    logic [WIDTH-1:0]  prod_q;
    logic [CW-1:0]     cnt_q;

    logic [WIDTH-1:0]  mplr_next;
    logic              hist_next;
    logic [CW-1:0]     cnt_next;
    booth_sel_t        sel;
    logic [WIDTH-1:0]  pp;
    logic              stop;

    always_comb begin
        mplr_next = {{2{mplr_q[WIDTH-1]}}, mplr_q[WIDTH-1:2]};
        hist_next = mplr_q[1];
        cnt_next  = cnt_q + CW'(1);
    end

    eo_booth_recode u_recode (
        .triple_i ({mplr_q[1:0], hist_q}),
        .sel_o    (sel)
    );

    eo_booth_pp #(.WIDTH(WIDTH)) u_pp (
        .mcand_i (mcand_q),
        .sel_i   (sel),
        .pp_o    (pp)
    );

    eo_early_out #(.WIDTH(WIDTH), .MIN_ITER(MIN_ITER)) u_eo (
        .rest_i     ({mplr_next, hist_next}),
        .next_cnt_i (cnt_next),
        .stop_o     (stop)
    );

    eo_mul_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .stop_i  (stop),
        .state_o (state),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            mplr_q  <= '0;
            hist_q  <= 1'b0;
            acc_q   <= '0;
            sum_q   <= '0;
            prod_q  <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        mcand_q <= mcand_i;
                        mplr_q  <= mplier_i;
                    end
                end
                ST_LOAD: begin
                    acc_q  <= '0;
                    hist_q <= 1'b0;
                end
                ST_PREP: begin
                    cnt_q <= '0;
                end
                ST_ITER: begin
                    acc_q   <= acc_q + pp;
                    mcand_q <= {mcand_q[WIDTH-3:0], 2'b00};
                    mplr_q  <= mplr_next;
                    hist_q  <= hist_next;
                    cnt_q   <= cnt_next;
                end
                ST_DRAIN: begin
                    sum_q <= acc_q;
                end
                ST_STORE: begin
                    prod_q <= sum_q;
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign product_o = prod_q;

    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(product_o) |-> done_o); // R8
    AST_DIGIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ITER) |-> (cnt_q < CW'(ITERS))); // R2
    AST_FLOOR_MET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (cnt_q >= CW'(MIN_ITER))); // R3
    AST_REST_ZERO_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> ((&{mplr_q, hist_q}) || (~|{mplr_q, hist_q}))); // R2
endmodule

// File: tb/eo_booth_mul_bench.sv
module eo_booth_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [31:0] product_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    eo_booth_mul #(.WIDTH(32), .MIN_ITER(4)) u_eo_booth_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int sig_bits(input logic [31:0] b);
        for (int w = 1; w <= 32; w++) begin
            logic signed [31:0] t;
            t = b << (32 - w);
            t = t >>> (32 - w);
            if (t == b) return w;
        end
        return 32;
    endfunction

    function automatic int exp_lat(input logic [31:0] b);
        int n;
        n = (sig_bits(b) + 1) / 2;
        if (n < 4) n = 4;
        return n + 5;
    endfunction

    function automatic logic [31:0] exp_prod(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] p;
        p = 64'(longint'($signed(a)) * longint'($signed(b)));
        return p[31:0];
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input bit inject, input string lat_tag, output int lat);
        logic [31:0] prev;
        bit got;
        bit busy_ok;
        bit hold_ok;
        @(negedge clk);
        prev = product_o;
        start_i = 1'b1;
        mcand_i = a;
        mplier_i = b;
        lat = 0;
        got = 0;
        busy_ok = 1;
        hold_ok = 1;
        while (!got && lat < 64) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (!busy_o) busy_ok = 0;
            if (done_o) got = 1;
            else if (product_o != prev) hold_ok = 0;
            start_i = 1'b0;
            if (inject && lat == 3) begin
                start_i = 1'b1;
                mcand_i = ~a;
                mplier_i = $urandom;
            end
        end
        start_i = 1'b0;
        check(lat == exp_lat(b), lat_tag, "latency", lat, exp_lat(b));
        check(product_o == exp_prod(a, b), "R1", "product", product_o, exp_prod(a, b));
        check(busy_ok, "R5", "busy through op", busy_ok, 1);
        check(hold_ok, "R8", "product held during op", hold_ok, 1);
        @(negedge clk);
        check(!done_o && !busy_o, inject ? "R6" : "R7", "idle after done",
              {done_o, busy_o}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int lat;
        int lat2;
        logic [31:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && product_o == 0, "R9", "reset state",
              {busy_o, done_o, product_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 minimum latency cases
        run_op(32'd7, 32'd0, 0, "R3", lat);
        run_op(32'hFFFF_FFF3, 32'hFFFF_FFFF, 0, "R3", lat);
        run_op(32'd12345, 32'd1, 0, "R3", lat);
        run_op(32'h8000_0000, 32'd127, 0, "R3", lat);
        run_op(32'h7FFF_FFFF, 32'hFFFF_FF80, 0, "R3", lat);
        run_op(32'd3, 32'd128, 0, "R2", lat);
        // R4 full width and 26 significant bits
        run_op(32'h8000_0000, 32'h8000_0000, 0, "R4", lat);
        run_op(32'h1234_5678, 32'h7FFF_FFFF, 0, "R4", lat);
        run_op(32'hDEAD_BEEF, 32'h01FF_FFFF, 0, "R4", lat);
        run_op(32'h0000_0005, 32'hFE00_0000, 0, "R4", lat);

        // R10 same multiplier, different multiplicands
        run_op(32'd0, 32'h0003_1234, 0, "R2", lat);
        run_op(32'hFFFF_FFFF, 32'h0003_1234, 0, "R2", lat2);
        check(lat == lat2, "R10", "latency vs multiplicand", lat2, lat);

        // R6 start injected while busy
        run_op(32'h0000_1111, 32'h0ABC_DEF0, 1, "R6", lat);
        run_op(32'hFFFF_0001, 32'd2, 1, "R6", lat);

        // R8 product held while idle with inputs changing
        held = product_o;
        for (int i = 0; i < 6; i++) begin
            mcand_i = $urandom;
            mplier_i = $urandom;
            @(negedge clk);
        end
        check(product_o == held && !done_o, "R8", "product held idle", product_o, held);

        // random operands with random significance
        for (int i = 0; i < 300; i++) begin
            logic signed [31:0] b;
            logic [31:0] a;
            a = $urandom;
            b = $urandom;
            b = b >>> $urandom_range(0, 31);
            run_op(a, b, (i % 17) == 0, "R2", lat);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule